// File: doc/BRIEF.md
# Long-Frame-Sync Variable-Rate PCM Transmitter

This block drives the transmit half of a serial PCM highway that uses long frame sync. A fast system clock oversamples the transmit bit clock and the transmit frame sync. From them the block recognises long-frame operation and measures how long frame sync stays high, in bit-clock periods. That length is the rate request for the encoder: 2 bits (16 kbps ADPCM), 3 bits (24 kbps), 4 bits (32 kbps) or 8 bits (64 kbps PCM).

Each rate request passes through a small per-frame delay line before it reaches the encoder and before it sets the word size on the line. The delay is 2 frames by default and 6 frames when the six-frame select is set. Only the length information is delayed. The sample word supplied by the encoder is shifted out MSB first at once, on a tri-state line. The line is driven from the start of frame sync until half a bit period before the end of the word's last bit, or until frame sync drops, whichever comes first.

All edges are detected in the system clock domain. An input change is acted on at the first system clock edge that sees it, and the registered outputs show the result right after that edge.

Top module: `pcm_lfs_tx`

## Requirements
- R1: While reset is asserted, txDrive is 0. All six delay entries hold rate code 3, so rateReq reads 3.
- R2: At the system clock edge that first sees frameSync high after it was low, txDrive becomes 1.
- R3: The word's first bit, txWord[7], appears on txLine at the first edge where frameSync AND bitClk is seen rising. This holds whichever of the two rose first. Each later bitClk rise puts the next lower bit on txLine.
- R4: Rate codes map to word sizes as 0→2, 1→3, 2→4 and 3→8 bits. On the bitClk fall inside the last bit of the word, txDrive drops to 0. The line is therefore driven for the word size minus half a bit period.
- R5: At the edge that sees frameSync fall, txDrive drops to 0, even in the middle of a word.
- R6: After a word ends, the line stays undriven and no bit is relaunched for the rest of that frame-sync pulse, however long the pulse lasts.
- R7: A frame counts only if frameSync was high on at least two bitClk falls. A shorter pulse leaves the rate delay line unchanged.
- R8: The number of bitClk falls seen while frameSync is high selects the rate code: 2→0, 3→1, 4→2, 8→3. Any other count gives code 3.
- R9: With sixFrameDelay at 0, the code measured in frame n appears on rateReq and sets the word size from the end of frame n+1 through frame n+2. It is replaced when frame n+2 ends.
- R10: With sixFrameDelay at 1, the code measured in frame n is the one on rateReq six counted frames later.
- R11: The word shifted out is the txWord value at the launch edge. The sample data is never delayed with the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial signals |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Transmit bit clock, synchronous to clk |
| frameSync | input | 1 | Transmit frame sync / output enable |
| sixFrameDelay | input | 1 | 1 selects the six-frame rate delay, 0 the two-frame delay |
| txWord | input | 8 | Sample word from the encoder, MSB-aligned |
| txLine | output | 1 | Tri-state serial data output |
| txDrive | output | 1 | High while txLine is driven |
| rateReq | output | 2 | Delayed rate code for the encoder and the word size |

## Verification
The bench starts frame sync at three phases of the bit clock: together with the bit clock rise, ahead of it, and after it. A design that launches the MSB on only one of the two edges would then put out a shifted word or no first bit. Pulses of 2, 3, 4, 5, 8 and 12 bit periods, plus one-period and sub-period pulses, check the length decode, the default code and the rule for ignoring short frames. Wrong handling there shows up as a rate that moves when it should not, or takes the wrong value. Frame sync that ends in the middle of a long word, and frame sync that outlasts a short word, expose a release made on a late or early edge and a word that restarts. Runs of frames with both delay settings catch a delay line tapped one stage off.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef logic [1:0] rate_t;

  localparam rate_t RATE_64K = 2'd3;

  typedef struct packed {
    logic  driveOn;
    logic  driveOff;
    logic  loadMsb;
    logic  shiftBit;
    logic  commit;
    rate_t code;
  } tx_strobe_t;

  function automatic rate_t len_to_rate(input int falls);
    case (falls)
      2:       return 2'd0;
      3:       return 2'd1;
      4:       return 2'd2;
      default: return RATE_64K;
    endcase
  endfunction

  function automatic logic [3:0] rate_last_idx(input rate_t r);
    case (r)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd3;
      default: return 4'd7;
    endcase
  endfunction

endpackage

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             frameSync,
  input  logic [IDX_W-1:0] lenM1,
  output tx_strobe_t       strb
);

  typedef enum logic [1:0] {IDLE, ARMED, SHIFT} tx_state_e;

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] MIN_LONG = CNT_W'(2);

  tx_state_e        txState;
  logic [IDX_W-1:0] bitCnt;
  logic [CNT_W-1:0] fallCnt;
  logic             fsPrev, bclkPrev;
  logic             fsRise, fsFall, bRise, bFall, andRise, lastBit;

  always_comb begin
    fsRise  = frameSync & ~fsPrev;
    fsFall  = ~frameSync & fsPrev;
    bRise   = bitClk & ~bclkPrev;
    bFall   = ~bitClk & bclkPrev;
    andRise = (frameSync & bitClk) & ~(fsPrev & bclkPrev);
    lastBit = (bitCnt == lenM1);

    strb          = '0;
    strb.driveOn  = fsRise;
    strb.loadMsb  = andRise & ((txState == ARMED) | fsRise);
    strb.shiftBit = bRise & frameSync & (txState == SHIFT) & ~lastBit;
    strb.driveOff = fsFall | (bFall & (txState == SHIFT) & lastBit);
    strb.commit   = fsFall & (fallCnt >= MIN_LONG);
    strb.code     = len_to_rate(int'(fallCnt));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= IDLE;
      bitCnt   <= '0;
      fallCnt  <= '0;
      fsPrev   <= 1'b0;
      bclkPrev <= 1'b0;
    end else begin
      fsPrev   <= frameSync;
      bclkPrev <= bitClk;

      if (strb.driveOff) begin
        txState <= IDLE;
      end else if (strb.loadMsb) begin
        txState <= SHIFT;
        bitCnt  <= '0;
      end else if (strb.driveOn) begin
        txState <= ARMED;
      end else if (strb.shiftBit) begin
        bitCnt <= bitCnt + 1'b1;
      end

      if (fsRise) begin
        fallCnt <= CNT_W'(bFall);
      end else if (frameSync && bFall && fallCnt != CNT_MAX) begin
        fallCnt <= fallCnt + 1'b1;
      end
    end
  end

  // R3: a launch never coincides with a shift of the previous word
  a_r3_single_launch: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMsb |-> !strb.shiftBit);

endmodule

// File: rtl/pcm_tx_dp.sv
module pcm_tx_dp
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int DEPTH     = 6,
  parameter int SHORT_TAP = 2,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tx_strobe_t        strb,
  input  logic              sixFrame,
  input  logic [WORD_W-1:0] txWord,
  output logic              txBit,
  output logic              txDrive,
  output rate_t             rateReq,
  output logic [IDX_W-1:0]  lenM1
);

  logic [WORD_W-1:0] shReg;
  logic              oeQ;
  rate_t             rateLine [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      oeQ   <= 1'b0;
    end else begin
      if (strb.driveOff)      oeQ <= 1'b0;
      else if (strb.driveOn)  oeQ <= 1'b1;

      if (strb.loadMsb)       shReg <= txWord;
      else if (strb.shiftBit) shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) rateLine[i] <= RATE_64K;
    end else if (strb.commit) begin
      rateLine[0] <= strb.code;
      for (int i = 1; i < DEPTH; i++) rateLine[i] <= rateLine[i-1];
    end
  end

  assign rateReq = sixFrame ? rateLine[DEPTH-1] : rateLine[SHORT_TAP-1];
  assign lenM1   = IDX_W'(rate_last_idx(rateReq));
  assign txBit   = shReg[WORD_W-1];
  assign txDrive = oeQ;

  // R9: the delayed rate moves only when a frame is committed or the tap changes
  a_r9_rate_steps_per_frame: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(rateReq) || !$stable(sixFrame)));

endmodule

// File: rtl/pcm_lfs_tx.sv
module pcm_lfs_tx
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int DEPTH     = 6,
  parameter int SHORT_TAP = 2,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              frameSync,
  input  logic              sixFrameDelay,
  input  logic [WORD_W-1:0] txWord,
  output logic              txLine,
  output logic              txDrive,
  output logic [1:0]        rateReq
);

  localparam int IDX_W = $clog2(WORD_W);

  tx_strobe_t       strb;
  logic [IDX_W-1:0] lenM1;
  logic             txBit;

  pcm_tx_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .lenM1(lenM1), .strb(strb)
  );

  pcm_tx_dp #(.WORD_W(WORD_W), .DEPTH(DEPTH), .SHORT_TAP(SHORT_TAP), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sixFrame(sixFrameDelay), .txWord(txWord),
    .txBit(txBit), .txDrive(txDrive), .rateReq(rateReq), .lenM1(lenM1)
  );

  assign txLine = txDrive ? txBit : 1'bz;

  // R2: frame sync rising turns the driver on
  a_r2_drive_at_fs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |=> txDrive);

  // R5: frame sync falling releases the line
  a_r5_release_at_fs_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameSync) |=> !txDrive);

  // R6: no drive while frame sync stays low
  a_r6_quiet_without_fs: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !$fell(frameSync)) |-> !txDrive);

endmodule

// File: tb/pcm_lfs_tx_bench.sv
module pcm_lfs_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitClk = 1'b0;
  logic       frameSync = 1'b0;
  logic       sixFrameDelay = 1'b0;
  logic [7:0] txWord = 8'h00;
  wire        txLine;
  logic       txDrive;
  logic [1:0] rateReq;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  bit    checkEn = 1'b0;
  string curReq = "R1";
  int    ph = 0;

  // reference model state
  bit         mPrevFs = 1'b0, mPrevB = 1'b0;
  bit         expDrive = 1'b0, expBit = 1'b0, mArmed = 1'b0, mActive = 1'b0;
  int         mFalls = 0, mIdx = 0, expRate = 3;
  logic [7:0] mWord = 8'h00;
  int         q[$] = '{3, 3, 3, 3, 3, 3};

  pcm_lfs_tx u_pcm_lfs_tx (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .sixFrameDelay(sixFrameDelay), .txWord(txWord), .txLine(txLine),
    .txDrive(txDrive), .rateReq(rateReq)
  );

  always #5 clk = ~clk;

  function automatic int codeOf(input int n);
    if (n == 2) return 0;
    if (n == 3) return 1;
    if (n == 4) return 2;
    return 3;
  endfunction

  function automatic int bitsOf(input int c);
    if (c == 0) return 2;
    if (c == 1) return 3;
    if (c == 2) return 4;
    return 8;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : mdl
    int  nb;
    bit  fsR, fsF, bR, bF, aR;
    if (rstN) begin
      nb  = bitsOf(sixFrameDelay ? q[5] : q[1]);
      fsR = frameSync && !mPrevFs;
      fsF = !frameSync && mPrevFs;
      bR  = bitClk && !mPrevB;
      bF  = !bitClk && mPrevB;
      aR  = (frameSync && bitClk) && !(mPrevFs && mPrevB);
      if (fsF) begin
        expDrive = 1'b0; mActive = 1'b0; mArmed = 1'b0;
        if (mFalls >= 2) begin
          q.push_front(codeOf(mFalls));
          void'(q.pop_back());
        end
      end else begin
        if (fsR) begin
          expDrive = 1'b1; mArmed = 1'b1; mActive = 1'b0; mFalls = 0;
        end
        if (frameSync && bF) mFalls++;
        if (mArmed && aR) begin
          mArmed = 1'b0; mActive = 1'b1; mIdx = 0;
          mWord = txWord; expBit = txWord[7];
        end else if (mActive && bR && mIdx < nb - 1) begin
          mIdx++;
          expBit = mWord[7 - mIdx];
        end else if (mActive && bF && mIdx == nb - 1) begin
          expDrive = 1'b0; mActive = 1'b0;
        end
      end
      mPrevFs = frameSync;
      mPrevB  = bitClk;
      expRate = sixFrameDelay ? q[5] : q[1];
    end
    #2;
    if (checkEn) begin
      vectors++;
      if (txDrive !== expDrive) begin
        miscompares++;
        $display("FAIL %s drive: got %0d expected %0d", curReq, txDrive, expDrive);
      end else if (expDrive && mActive && txLine !== expBit) begin
        miscompares++;
        $display("FAIL %s data bit %0d: got %0d expected %0d", curReq, mIdx, txLine, expBit);
      end
      if (rateReq !== 2'(expRate)) begin
        miscompares++;
        $display("FAIL %s rate: got %0d expected %0d", curReq, rateReq, expRate);
      end
    end
  end

  task automatic step(input bit fs);
    @(negedge clk);
    ph        = (ph + 1) % 8;
    bitClk    = (ph < 4);
    frameSync = fs;
  endtask

  task automatic frame(input int lenClk, input int startPh, input logic [7:0] w, input string req);
    while (((ph + 1) % 8) != startPh) step(1'b0);
    curReq = req;
    txWord = w;
    repeat (lenClk) step(1'b1);
    repeat (40) step(1'b0);
  endtask

  initial begin
    repeat (4) step(1'b0);
    chk("R1", "drive in reset", int'(txDrive), 0);
    chk("R1", "rate in reset", int'(rateReq), 3);
    step(1'b0);
    rstN = 1'b1;
    checkEn = 1'b1;
    chk("R1", "rate after reset", int'(rateReq), 3);

    // R9: two-frame delay of the measured length
    frame(16, 0, 8'hA5, "R9");
    frame(24, 0, 8'h3C, "R9");
    chk("R9", "rate from two frames back", int'(rateReq), 0);
    frame(32, 0, 8'hF0, "R9");
    chk("R9", "rate from two frames back", int'(rateReq), 1);

    // R8: length decode and default
    frame(32, 0, 8'h96, "R8");
    frame(40, 0, 8'h69, "R8");
    chk("R8", "four periods give code 2", int'(rateReq), 2);
    frame(24, 0, 8'hC3, "R8");
    chk("R8", "five periods default to 3", int'(rateReq), 3);
    frame(64, 0, 8'h5A, "R8");
    frame(16, 0, 8'hE1, "R8");
    chk("R8", "eight periods give code 3", int'(rateReq), 3);

    // R4: release half a period before the word ends
    frame(64, 0, 8'hB7, "R4");
    frame(64, 0, 8'h4D, "R4");

    // R3 and R2: frame sync ahead of or after the bit clock
    frame(64, 6, 8'hD2, "R3");
    frame(64, 2, 8'h2D, "R3");
    frame(64, 5, 8'h9B, "R2");

    // R5: frame sync ends mid-word
    frame(24, 0, 8'h81, "R5");
    chk("R5", "drive after cut frame", int'(txDrive), 0);

    // R6: long pulse after a short word
    frame(16, 0, 8'h7E, "R6");
    frame(96, 0, 8'hCA, "R6");
    chk("R6", "rate after long pulse", int'(rateReq), 0);

    // R7: pulses too short for long-frame mode
    frame(8, 0, 8'hFF, "R7");
    frame(3, 0, 8'h00, "R7");
    chk("R7", "rate unchanged by short pulses", int'(rateReq), 0);

    // R10 and R11: six-frame delay, fresh data each frame
    sixFrameDelay = 1'b1;
    frame(16, 0, 8'h11, "R10");
    frame(24, 0, 8'h22, "R10");
    frame(32, 0, 8'h44, "R10");
    frame(16, 0, 8'h88, "R11");
    frame(24, 0, 8'hA3, "R11");
    frame(32, 0, 8'h5C, "R11");
    chk("R10", "rate from six frames back", int'(rateReq), 0);
    frame(64, 0, 8'hE7, "R10");
    chk("R10", "rate from six frames back", int'(rateReq), 1);

    repeat (20) step(1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL %s watchdog: got hang expected completion", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule